// File: doc/BRIEF.md
# Clear-to-Send Transmit Gate

This block sits between a serial transmitter's character shifter and the active-low clear-to-send line from the far end. Its job is to keep the remote receiver's FIFO from being overrun. The line is brought into the clock domain through a flip-flop chain. When automatic gating is enabled and the line is deasserted (high), the gate withdraws its transmit permit. The permit drops only on a character boundary. A character the shifter has already begun always runs through its stop bit, and the permit falls at the same clock edge that reports the end of that stop bit. When the line is asserted again, the permit comes back.

Each deassertion seen while gating is enabled also latches a status flag. The flag drives an interrupt when the interrupt-enable bit is set. That enable bit can only be written while the enhanced-function enable is high. A status read by the host clears the flag.

All pins are plain levels or single-cycle strobes. No data stream passes through the block, so it has no valid/ready handshake. The shifter must look at the permit only when it is about to begin a character, and it must not begin one while the permit is low.

Top module: `cts_tx_gate`

## Requirements
- R1: While reset is asserted, `tx_permit`, `cts_status` and `cts_irq` are all 0. The interrupt-enable bit resets to 0. The synchronised line resets to the deasserted level, so no status event follows reset.
- R2: While no character is in flight and automatic gating is on, a change on `cts_n` reaches `tx_permit` at the third rising clock edge after the change. Across the first two of those edges the permit keeps its old value.
- R3: When `auto_cts_en` is 0, `tx_permit` is 1 from the first clock edge after reset onward, whatever the level of `cts_n`.
- R4: Once a character has been accepted, `tx_permit` stays 1 until `stop_done` is seen. A character is accepted when `chr_start` is high together with `tx_permit`. At the edge that samples `stop_done`, the permit takes the value the current line level allows: 0 if gating is on and the line is high.
- R5: With gating on, returning `cts_n` to 0 brings `tx_permit` back to 1 (with R2 timing when idle).
- R6: With `auto_cts_en` at 1, a 0-to-1 transition of the synchronised line sets `cts_status`, which appears at the same edge as the R2 permit change. With gating off, no status is set.
- R7: A one-cycle `isr_read` clears `cts_status` at the next edge. If a new deassertion event arrives in the same cycle, the set takes priority.
- R8: `cts_irq` equals `cts_status` AND the interrupt-enable bit. A write (`ier_wr` with value `ier_cts_bit`) changes the enable bit only when `ext_func_en` is 1. Otherwise the write has no effect.
- R9: A `chr_start` pulse while `tx_permit` is 0 is ignored. It does not mark a character in flight and so does not raise the permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n | input | 1 | Clear-to-send from the far end, active low, asynchronous |
| auto_cts_en | input | 1 | Enables automatic transmit gating |
| ext_func_en | input | 1 | Enhanced-function enable; unlocks the interrupt-enable bit |
| ier_wr | input | 1 | Write strobe for the interrupt-enable bit |
| ier_cts_bit | input | 1 | Value written to the interrupt-enable bit |
| isr_read | input | 1 | Host status-read strobe; clears the status flag |
| chr_start | input | 1 | Shifter begins a character this cycle |
| stop_done | input | 1 | Shifter finished the stop bit of the current character |
| tx_permit | output | 1 | Shifter may begin a new character |
| cts_status | output | 1 | Latched clear-to-send deassertion flag |
| cts_irq | output | 1 | Clear-to-send interrupt request |

## Verification
A stale in-flight marker shows up at the port in one of two ways. The permit may stay high after a stop bit while the line is deasserted, which is visible at the next sampling point. Or it may rise one edge after an ignored start pulse. A wrong synchroniser depth or a wrong edge detector moves the permit and status changes off the third edge after the line moves, so the bench samples both on either side of that edge. An unlocked or stuck interrupt-enable bit appears on `cts_irq` as soon as the status flag is next set.

// File: rtl/cts_gate_pkg.sv
package cts_gate_pkg;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  typedef enum logic [1:0] {
    GT_HALT = 2'd0,
    GT_OPEN = 2'd1,
    GT_BUSY = 2'd2
  } gate_mode_e;
endpackage

// File: rtl/cts_line_sync.sv
module cts_line_sync #(
  parameter int unsigned DEPTH = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned LAST = DEPTH - 1;
  logic [LAST:0] stg;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RST_VAL;
          else        stg[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[LAST];
endmodule

// File: rtl/cts_permit_ctl.sv
module cts_permit_ctl
  import cts_gate_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic cts_hi,
  input  logic chr_start,
  input  logic stop_done,
  output logic permit,
  output logic in_flight,
  output gate_mode_e mode
);
  logic allowed;
  logic start_ok;
  logic busy_d;
  logic permit_d;

  assign allowed  = !auto_en || !cts_hi;
  assign start_ok = chr_start && permit;
  assign busy_d   = start_ok || (in_flight && !stop_done);
  assign permit_d = busy_d ? 1'b1 : allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_flight <= 1'b0;
      permit    <= 1'b0;
    end else begin
      in_flight <= busy_d;
      permit    <= permit_d;
    end
  end

  always_comb begin
    if (in_flight)   mode = GT_BUSY;
    else if (permit) mode = GT_OPEN;
    else             mode = GT_HALT;
  end
endmodule

// File: rtl/cts_event_unit.sv
module cts_event_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic cts_hi,
  input  logic ext_func_en,
  input  logic ier_wr,
  input  logic ier_cts_bit,
  input  logic isr_read,
  output logic rise_evt,
  output logic status,
  output logic irq_en,
  output logic irq
);
  logic cts_prev;

  assign rise_evt = auto_en && cts_hi && !cts_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_prev <= 1'b1;
      status   <= 1'b0;
      irq_en   <= 1'b0;
    end else begin
      cts_prev <= cts_hi;
      if (rise_evt)      status <= 1'b1;
      else if (isr_read) status <= 1'b0;
      if (ier_wr && ext_func_en) irq_en <= ier_cts_bit;
    end
  end

  assign irq = status && irq_en;
endmodule

// File: rtl/cts_tx_gate.sv
module cts_tx_gate
  import cts_gate_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic auto_cts_en,
  input  logic ext_func_en,
  input  logic ier_wr,
  input  logic ier_cts_bit,
  input  logic isr_read,
  input  logic chr_start,
  input  logic stop_done,
  output logic tx_permit,
  output logic cts_status,
  output logic cts_irq
);
  logic cts_s;
  logic busy;
  logic irq_en;
  logic cts_rise;
  gate_mode_e gmode;

  cts_line_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cts_n), .dout(cts_s)
  );

  cts_permit_ctl u_gate (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_cts_en), .cts_hi(cts_s),
    .chr_start(chr_start), .stop_done(stop_done),
    .permit(tx_permit), .in_flight(busy), .mode(gmode)
  );

  cts_event_unit u_evt (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_cts_en), .cts_hi(cts_s),
    .ext_func_en(ext_func_en), .ier_wr(ier_wr), .ier_cts_bit(ier_cts_bit),
    .isr_read(isr_read), .rise_evt(cts_rise), .status(cts_status),
    .irq_en(irq_en), .irq(cts_irq)
  );

  logic unused_mode;
  assign unused_mode = ^gmode;
endmodule

// File: rtl/cts_tx_gate_chk.sv
module cts_tx_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_cts_en,
  input logic ext_func_en,
  input logic isr_read,
  input logic chr_start,
  input logic stop_done,
  input logic tx_permit,
  input logic cts_status,
  input logic cts_s,
  input logic busy,
  input logic irq_en,
  input logic set_evt
);
  AST_HOLD_MIDCHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop_done) |=> tx_permit); // R4
  AST_SUSPEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && auto_cts_en && cts_s && !(chr_start && tx_permit)) |=> !tx_permit); // R2
  AST_NO_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_cts_en |=> tx_permit); // R3
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> cts_status); // R6
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_read && !set_evt) |=> !cts_status); // R7
  AST_IER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_func_en |=> $stable(irq_en)); // R8
endmodule

bind cts_tx_gate cts_tx_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .auto_cts_en(auto_cts_en), .ext_func_en(ext_func_en),
  .isr_read(isr_read), .chr_start(chr_start), .stop_done(stop_done),
  .tx_permit(tx_permit), .cts_status(cts_status), .cts_s(cts_s), .busy(busy),
  .irq_en(irq_en), .set_evt(cts_rise)
);

// File: tb/sim_cts_tx_gate.sv
module sim_cts_tx_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n = 1'b0;
  logic auto_cts_en = 1'b0;
  logic ext_func_en = 1'b0;
  logic ier_wr = 1'b0;
  logic ier_cts_bit = 1'b0;
  logic isr_read = 1'b0;
  logic chr_start = 1'b0;
  logic stop_done = 1'b0;
  logic tx_permit, cts_status, cts_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cts_tx_gate u0 (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .auto_cts_en(auto_cts_en),
    .ext_func_en(ext_func_en), .ier_wr(ier_wr), .ier_cts_bit(ier_cts_bit),
    .isr_read(isr_read), .chr_start(chr_start), .stop_done(stop_done),
    .tx_permit(tx_permit), .cts_status(cts_status), .cts_irq(cts_irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_start();
    chr_start = 1'b1; tick(1); chr_start = 1'b0;
  endtask
  task automatic pulse_stop();
    stop_done = 1'b1; tick(1); stop_done = 1'b0;
  endtask
  task automatic pulse_read();
    isr_read = 1'b1; tick(1); isr_read = 1'b0;
  endtask
  task automatic write_ier(input logic v);
    ier_cts_bit = v; ier_wr = 1'b1; tick(1); ier_wr = 1'b0;
  endtask

  initial begin
    tick(3);
    chk("R1 permit", tx_permit, 1'b0);
    chk("R1 status", cts_status, 1'b0);
    chk("R1 irq", cts_irq, 1'b0);
    rst_n = 1'b1;
    tick(1);
    chk("R3 permit after reset", tx_permit, 1'b1);
    chk("R1 no status after reset", cts_status, 1'b0);
    ext_func_en = 1'b1;
    write_ier(1'b1);

    for (int a = 0; a < 2; a++) begin
      for (int f = 0; f < 2; f++) begin
        auto_cts_en = logic'(a);
        cts_n = 1'b0; tick(4);
        chk("R5 permit line low", tx_permit, 1'b1);
        if (f == 1) pulse_start();
        cts_n = 1'b1; tick(2);
        chk("R2 permit before third edge", tx_permit, 1'b1);
        chk("R6 status before third edge", cts_status, 1'b0);
        tick(1);
        chk((f == 1) ? "R4 permit held mid-char" : "R2 R3 permit third edge",
            tx_permit, (f == 1) ? 1'b1 : logic'(a == 0));
        chk("R6 status on deassert", cts_status, logic'(a));
        chk("R8 irq follows status", cts_irq, logic'(a));
        tick(3);
        chk("R4 R3 permit steady", tx_permit, (f == 1) ? 1'b1 : logic'(a == 0));
        if (f == 1) begin
          pulse_stop();
          chk("R4 permit after stop bit", tx_permit, logic'(a == 0));
        end
        pulse_read();
        chk("R7 status cleared", cts_status, 1'b0);
        chk("R7 irq cleared", cts_irq, 1'b0);
        cts_n = 1'b0; tick(3);
        chk("R5 permit resumes", tx_permit, 1'b1);
        tick(1);
      end
    end

    // R9: start pulse while suspended
    auto_cts_en = 1'b1;
    cts_n = 1'b1; tick(4);
    chk("R9 suspended", tx_permit, 1'b0);
    pulse_start();
    tick(1);
    chk("R9 start ignored", tx_permit, 1'b0);
    cts_n = 1'b0; tick(4);
    chk("R9 R5 resumed", tx_permit, 1'b1);
    cts_n = 1'b1; tick(4);
    chk("R9 no stale in-flight", tx_permit, 1'b0);
    pulse_read();
    cts_n = 1'b0; tick(4);

    // R8: enable-bit lock
    write_ier(1'b0);
    ext_func_en = 1'b0;
    write_ier(1'b1);
    cts_n = 1'b1; tick(4);
    chk("R8 locked write ignored status", cts_status, 1'b1);
    chk("R8 locked write ignored irq", cts_irq, 1'b0);
    ext_func_en = 1'b1;
    write_ier(1'b1);
    chk("R8 unlocked write irq", cts_irq, 1'b1);
    ext_func_en = 1'b0;
    write_ier(1'b0);
    chk("R8 locked clear ignored", cts_irq, 1'b1);
    ext_func_en = 1'b1;
    write_ier(1'b0);
    chk("R8 unlocked clear", cts_irq, 1'b0);
    pulse_read();
    cts_n = 1'b0; tick(4);

    // R6: gating off sets no status
    auto_cts_en = 1'b0;
    cts_n = 1'b1; tick(4);
    chk("R6 no status gating off", cts_status, 1'b0);
    chk("R3 permit gating off line high", tx_permit, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule